// File: doc/BRIEF.md
# Presettable Cascadable Synchronous Binary Counter

The block is an up-counter built from a chain of equal-width stages that all update on the same rising clock edge. A single count value `q` is presented across the whole chain. Software-free control comes through plain pins: an active-low clear, an active-low parallel load of `d`, and two count enables. Counting needs both enables high. The "carry-in" enable (`ent`) also qualifies the terminal-count output `rco`, so several blocks can be chained into a wider counter: feed one block's `rco` into the next block's `ent` and share `enp`.

Inside, each stage drives its own carry into the next stage's `ent`. The chain therefore behaves as one binary counter of `STAGE_W * STAGES` bits, with no ripple between stages on the clock. A build-time parameter `ASYNC_CLR` selects the clear style. With the value 1 the clear acts at once, without a clock edge. With the value 0 the clear takes effect on the next rising edge. The synchronous style lets a decode of a chosen terminal value, fed back into `clr_n`, shorten the count cycle to any modulus.

All pins are plain control and status pins. The block carries no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `chain_counter`

## Requirements
- R1: All bits of `q`, across every stage, change together on the same rising edge of `clk`; a carry from a full lower stage advances the upper stage on that same edge (for example 0x0F to 0x10).
- R2: With `clr_n` high and `load_n` low, `q` takes the value of `d` at the next rising edge, whatever the levels of `enp` and `ent`.
- R3: With `ASYNC_CLR`=1, `clr_n` low forces `q` to zero at once, with no clock edge. With `ASYNC_CLR`=0, `clr_n` low forces `q` to zero at the next rising edge, whatever the levels of `load_n`, `enp` and `ent`.
- R4: With `clr_n` and `load_n` high and both `enp` and `ent` high, `q` increments by one at each rising edge. From all ones it wraps to zero.
- R5: With `clr_n` and `load_n` high and either enable low, `q` holds its value.
- R6: `rco` is high exactly when `ent` is high and `q` is all ones. It is combinational from `q` and `ent`, so it falls in the cycle after a wrap to zero.
- R7: A change on `load_n`, `enp`, `ent` or `d` between clock edges leaves `q` unchanged until the next rising edge.
- R8: The chain of `STAGES` stages counts as a single binary counter of `STAGE_W*STAGES` bits. An upper stage advances only on an edge where every stage below it holds all ones.
- R9: With `ASYNC_CLR`=0 and `clr_n` driven low by a decode of q == N, the counter steps 0, 1, ..., N and then returns to 0.
- R10: Clear takes priority over load, load over counting, and counting over hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for every state bit |
| clr_n | input | 1 | Active-low clear; immediate or edge-timed, chosen by `ASYNC_CLR` |
| load_n | input | 1 | Active-low parallel load of `d` |
| ent | input | 1 | Count enable that also qualifies `rco`; the carry-in of a chain |
| enp | input | 1 | Count enable that has no effect on `rco` |
| d | input | STAGE_W*STAGES | Parallel load value |
| q | output | STAGE_W*STAGES | Present count |
| rco | output | 1 | Terminal-count carry: `ent` and `q` all ones |

## Verification
The bench goes after the carry at the boundary between two stages. A chain whose carry is registered, or that takes it from the wrong stage, would step from 0x0F to 0x00 or to 0x1F instead of to 0x10. It checks the wrap from all ones, and checks that `rco` follows `ent` while `enp` is low. A design that gated the carry with `enp`, or registered it, would show `rco` wrongly low or one cycle late. It pits clear against load and load against counting, where a wrong priority yields the load value or an incremented value. It also checks that the immediate clear acts between edges while the edge-timed clear waits, and that a terminal decode gives a ten-state cycle, which an asynchronous or one-cycle-late clear would cut to nine states or stretch to eleven.

// File: rtl/chain_cnt_pkg.sv
`timescale 1ns/1ps
package chain_cnt_pkg;
  // Action taken by a stage at the next rising edge, lowest to highest priority.
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } cnt_op_e;
endpackage

// File: rtl/cnt_ctrl.sv
`timescale 1ns/1ps
module cnt_ctrl
  import chain_cnt_pkg::*;
(
  input  logic    clear_req,
  input  logic    load_n,
  input  logic    step,
  output cnt_op_e op
);
  // R10: clear over load, load over count, count over hold.
  always_comb begin
    if (clear_req)    op = OP_CLEAR;
    else if (!load_n) op = OP_LOAD;
    else if (step)    op = OP_COUNT;
    else              op = OP_HOLD;
  end
endmodule

// File: rtl/cnt_stage.sv
`timescale 1ns/1ps
module cnt_stage
  import chain_cnt_pkg::*;
#(
  parameter int W         = 4,
  parameter bit ASYNC_CLR = 1'b0
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         load_n,
  input  logic         ent,
  input  logic         enp,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         rco
);
  localparam logic [W-1:0] ALL_ONES = '1;
  localparam logic [W-1:0] ONE      = W'(1);

  logic         clear_req;
  cnt_op_e      op;
  logic [W-1:0] q_r;
  logic [W-1:0] q_nxt;

  // An immediate clear acts outside the edge-timed mux.
  assign clear_req = ASYNC_CLR ? 1'b0 : !clr_n;

  cnt_ctrl u_ctrl (
    .clear_req (clear_req),
    .load_n    (load_n),
    .step      (enp & ent),
    .op        (op)
  );

  always_comb begin
    unique case (op)
      OP_CLEAR: q_nxt = '0;
      OP_LOAD:  q_nxt = d;
      OP_COUNT: q_nxt = q_r + ONE;
      default:  q_nxt = q_r;
    endcase
  end

  generate
    if (ASYNC_CLR) begin : g_async_clr
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) q_r <= '0;
        else        q_r <= q_nxt;
      end
    end else begin : g_sync_clr
      always_ff @(posedge clk) begin
        q_r <= q_nxt;
      end
    end
  endgenerate

  assign q   = q_r;
  // R6: carry out is combinational, gated by ent only.
  assign rco = ent & (q_r == ALL_ONES);
endmodule

// File: rtl/chain_counter.sv
`timescale 1ns/1ps
module chain_counter #(
  parameter int STAGE_W   = 4,
  parameter int STAGES    = 2,
  parameter bit ASYNC_CLR = 1'b0
) (
  input  logic                        clk,
  input  logic                        clr_n,
  input  logic                        load_n,
  input  logic                        ent,
  input  logic                        enp,
  input  logic [STAGE_W*STAGES-1:0]   d,
  output logic [STAGE_W*STAGES-1:0]   q,
  output logic                        rco
);
  localparam int WIDTH = STAGE_W * STAGES;

  // carry[k] is the ent of stage k; carry[STAGES] leaves the block.
  logic [STAGES:0] carry;
  assign carry[0] = ent;

  // R8: each stage's carry enables the stage above; enp is shared.
  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      cnt_stage #(
        .W         (STAGE_W),
        .ASYNC_CLR (ASYNC_CLR)
      ) u_stage (
        .clk    (clk),
        .clr_n  (clr_n),
        .load_n (load_n),
        .ent    (carry[g]),
        .enp    (enp),
        .d      (d[g*STAGE_W +: STAGE_W]),
        .q      (q[g*STAGE_W +: STAGE_W]),
        .rco    (carry[g+1])
      );
    end
  endgenerate

  assign rco = carry[STAGES];
endmodule

// File: rtl/chain_counter_chk.sv
`timescale 1ns/1ps
module chain_counter_chk #(
  parameter int WIDTH     = 8,
  parameter bit ASYNC_CLR = 1'b0
) (
  input logic             clk,
  input logic             clr_n,
  input logic             load_n,
  input logic             ent,
  input logic             enp,
  input logic [WIDTH-1:0] d,
  input logic [WIDTH-1:0] q,
  input logic             rco
);
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  generate
    if (ASYNC_CLR == 0) begin : g_sync_props
      a_r3_sync_clear: assert property (@(posedge clk) disable iff (!armed)
        !clr_n |=> (q == '0));
      a_r2_load: assert property (@(posedge clk) disable iff (!armed)
        (clr_n && !load_n) |=> (q == $past(d)));
      a_r4_count: assert property (@(posedge clk) disable iff (!armed)
        (clr_n && load_n && enp && ent) |=> (q == WIDTH'($past(q) + 1'b1)));
      a_r5_hold: assert property (@(posedge clk) disable iff (!armed)
        (clr_n && load_n && !(enp && ent)) |=> $stable(q));
    end else begin : g_async_props
      a_r3_async_clear: assert property (@(posedge clk) disable iff (!armed)
        !clr_n |-> (q == '0));
    end
  endgenerate

  a_r6_carry_out: assert property (@(posedge clk) disable iff (!armed)
    rco == (ent && (&q)));
endmodule

bind chain_counter chain_counter_chk #(
  .WIDTH     (WIDTH),
  .ASYNC_CLR (ASYNC_CLR)
) u_chk (
  .clk    (clk),
  .clr_n  (clr_n),
  .load_n (load_n),
  .ent    (ent),
  .enp    (enp),
  .d      (d),
  .q      (q),
  .rco    (rco)
);

// File: tb/chain_counter_bench.sv
`timescale 1ns/1ps
module chain_counter_bench;
  localparam int W = 8;
  localparam int NV = 20;
  localparam logic [W-1:0] MOD_LAST = 8'd9;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic         clr_tb = 1'b0;
  logic         clr_a  = 1'b0;
  logic         mod_mode = 1'b0;
  logic         load_n = 1'b1;
  logic         enp = 1'b0;
  logic         ent = 1'b0;
  logic [W-1:0] d = '0;
  logic [W-1:0] q_s, q_a;
  logic         rco_s, rco_a;
  logic         clr_s;

  // R9: terminal-count decode drives the clear in modulus mode.
  assign clr_s = mod_mode ? (q_s != MOD_LAST) : clr_tb;

  chain_counter #(.STAGE_W(4), .STAGES(2), .ASYNC_CLR(1'b0)) u_chain_counter (
    .clk(clk), .clr_n(clr_s), .load_n(load_n), .ent(ent), .enp(enp),
    .d(d), .q(q_s), .rco(rco_s));

  chain_counter #(.STAGE_W(4), .STAGES(2), .ASYNC_CLR(1'b1)) u_chain_counter_async (
    .clk(clk), .clr_n(clr_a), .load_n(load_n), .ent(ent), .enp(enp),
    .d(d), .q(q_a), .rco(rco_a));

  int n_chk = 0;
  int n_bad = 0;

  task automatic check(input int req, input logic [W-1:0] got,
                       input logic [W-1:0] exp, input string what);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // {clr_n, load_n, enp, ent, d[8], q after edge[8], rco[1], req[4]}
  localparam logic [24:0] VEC [NV] = '{
    {1'b0,1'b1,1'b1,1'b1,8'h77,8'h00,1'b0,4'd3},   // R3 clear, reset state
    {1'b1,1'b0,1'b0,1'b0,8'h0C,8'h0C,1'b0,4'd2},   // R2 load with enables low
    {1'b1,1'b1,1'b1,1'b1,8'h00,8'h0D,1'b0,4'd4},   // R4
    {1'b1,1'b1,1'b1,1'b1,8'h00,8'h0E,1'b0,4'd4},
    {1'b1,1'b1,1'b1,1'b1,8'h00,8'h0F,1'b0,4'd4},
    {1'b1,1'b1,1'b1,1'b1,8'h00,8'h10,1'b0,4'd1},   // R1 stage carry same edge
    {1'b1,1'b1,1'b0,1'b1,8'h00,8'h10,1'b0,4'd5},   // R5 enp low
    {1'b1,1'b1,1'b1,1'b0,8'h00,8'h10,1'b0,4'd5},   // R5 ent low
    {1'b1,1'b0,1'b0,1'b0,8'hFD,8'hFD,1'b0,4'd2},
    {1'b1,1'b1,1'b1,1'b1,8'h00,8'hFE,1'b0,4'd4},
    {1'b1,1'b1,1'b1,1'b1,8'h00,8'hFF,1'b1,4'd6},   // R6 all ones
    {1'b1,1'b1,1'b1,1'b1,8'h00,8'h00,1'b0,4'd6},   // R6 falls after wrap
    {1'b1,1'b1,1'b1,1'b1,8'h00,8'h01,1'b0,4'd4},
    {1'b0,1'b0,1'b1,1'b1,8'h55,8'h00,1'b0,4'd10},  // R10 clear beats load
    {1'b1,1'b0,1'b1,1'b1,8'h3C,8'h3C,1'b0,4'd10},  // R10 load beats count
    {1'b1,1'b0,1'b1,1'b1,8'hFF,8'hFF,1'b1,4'd2},
    {1'b1,1'b1,1'b0,1'b1,8'h00,8'hFF,1'b1,4'd6},   // R6 enp does not gate rco
    {1'b1,1'b1,1'b1,1'b0,8'h00,8'hFF,1'b0,4'd6},   // R6 ent gates rco
    {1'b1,1'b1,1'b0,1'b0,8'h00,8'hFF,1'b0,4'd5},
    {1'b1,1'b1,1'b1,1'b1,8'h00,8'h00,1'b0,4'd4}
  };

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    summary();
  end

  initial begin
    logic [W-1:0] model;
    // Vector table: drive on falling edge, sample 1 ns after rising edge.
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {clr_tb, load_n, enp, ent, d} = VEC[i][24:13];
      @(posedge clk);
      #1;
      check(int'(VEC[i][3:0]), q_s, VEC[i][12:5], $sformatf("vector %0d q", i));
      check(int'(VEC[i][3:0]), {7'd0, rco_s}, {7'd0, VEC[i][4]},
            $sformatf("vector %0d rco", i));
    end
    check(3, q_a, 8'h00, "async instance held in clear");

    // R3: immediate clear acts between edges; edge-timed clear waits.
    @(negedge clk);
    clr_a = 1'b1; load_n = 1'b0; d = 8'h5A; enp = 1'b0; ent = 1'b0;
    @(posedge clk); #1;
    check(2, q_a, 8'h5A, "async instance load");
    @(negedge clk);
    load_n = 1'b1;
    #1 clr_a = 1'b0;
    #1;
    check(3, q_a, 8'h00, "immediate clear without edge");
    check(3, q_s, 8'h5A, "other instance untouched");
    clr_tb = 1'b0;
    #1;
    check(3, q_s, 8'h5A, "edge-timed clear waits for edge");
    @(posedge clk); #1;
    check(3, q_s, 8'h00, "edge-timed clear at edge");
    @(negedge clk);
    clr_tb = 1'b1; clr_a = 1'b1; load_n = 1'b0; d = 8'h5A;
    @(posedge clk); #1;

    // R7: mid-cycle changes wait for the edge.
    @(negedge clk);
    load_n = 1'b0; d = 8'hA5; enp = 1'b1; ent = 1'b1;
    #1;
    check(7, q_s, 8'h5A, "load held off until edge");
    @(posedge clk); #1;
    check(7, q_s, 8'hA5, "load at edge");

    // R8: long run across the stage boundary against a model.
    @(negedge clk);
    load_n = 1'b0; d = 8'h2E;
    model = 8'h2E;
    @(posedge clk); #1;
    @(negedge clk);
    load_n = 1'b1;
    for (int k = 0; k < 20; k++) begin
      @(posedge clk); #1;
      model = model + 8'd1;
      check(8, q_s, model, $sformatf("chain step %0d", k));
    end

    // R9: decode of 9 into the edge-timed clear gives a modulus of ten.
    @(negedge clk);
    clr_tb = 1'b0;
    @(posedge clk); #1;
    @(negedge clk);
    clr_tb = 1'b1; mod_mode = 1'b1;
    for (int k = 1; k <= 25; k++) begin
      @(posedge clk); #1;
      check(9, q_s, 8'(k % 10), $sformatf("modulus step %0d", k));
    end
    @(negedge clk);
    mod_mode = 1'b0;

    summary();
  end
endmodule